// File: doc/BRIEF.md
# Two-Level Preemptive Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core, decides each clock which one should be served next, and offers it to the core as a dispatch request carrying the winning source number and its priority level. Every source has its own enable bit and priority bit: a cleared priority bit means low, a set bit means high. One global enable gates all sources. Arbitration is combinational on the captured pending flags, so a request is decided in the clock right after it is captured.

Service nests two levels deep. A high-priority routine may interrupt a low-priority one. Nothing interrupts a high-priority routine. A request at the same level as the running routine, or below it, waits until that routine returns. After any return, one more instruction must retire before the next dispatch. The core reports three events to the block: vector call accepted (`call_ack`), return finished (`reti_done`) and instruction retired (`instr_retire`). The block uses these to keep one in-service flag per level and to enforce the one-instruction gap.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `disp_req` is 0 and neither in-service level is marked.
- R2: A source is eligible only while its pending flag, its `irq_en` bit and `glb_en` are all 1. An edge on a masked source is still captured and is offered once the masks allow it.
- R3: A rising edge on `irq_in[i]` that is present before clock edge k drives `disp_req` high with `disp_idx` = i after edge k. This is one clock of detection, provided that nothing blocks the request.
- R4: When sources at both levels are eligible, a source whose `irq_hi` bit is 1 wins over any source whose bit is 0. `disp_hi` shows the level of the winner.
- R5: Among eligible sources at the same level, the lowest index wins.
- R6: While `disp_req` is 1 and `call_ack` is 0, `disp_req`, `disp_idx` and `disp_hi` hold their values into the next cycle, even if a more urgent request arrives in the meantime.
- R7: A clock edge with `call_ack` and `disp_req` both 1 marks the offered level as in service and clears the offered source's pending flag. The same request is not offered again.
- R8: While only the low level is in service, an eligible high-priority request is offered.
- R9: While the high level is in service, no request is offered. While the low level is in service, low-priority requests are held pending.
- R10: `reti_done` clears the high in-service flag if it is set, and otherwise clears the low flag.
- R11: After a clock edge with `reti_done` = 1, no new dispatch is offered until a later clock edge with `instr_retire` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_SRC | Raw request lines, captured on the rising edge |
| irq_en | input | N_SRC | Per-source enable |
| irq_hi | input | N_SRC | Per-source priority, 1 = high |
| glb_en | input | 1 | Global interrupt enable |
| instr_retire | input | 1 | One instruction retired this cycle |
| reti_done | input | 1 | Return-from-interrupt completed this cycle |
| call_ack | input | 1 | Core accepts the offered vector call |
| disp_req | output | 1 | Dispatch offered |
| disp_idx | output | $clog2(N_SRC) | Index of the offered source |
| disp_hi | output | 1 | Level of the offered source |

## Verification
The hardest state to reach is two routines nested, with further requests waiting at both levels, followed by returns that must unwind the levels in the right order, each with its instruction gap. The stimulus builds this up step by step. It enters a low routine, parks a low request, preempts with a high source, and parks a second high request. It then issues return and retire pulses one at a time and checks, after each pulse, which source (if any) is offered. A separate sequence makes a high request arrive while a low offer is still waiting for acceptance, which shows that the offer does not change until it is accepted.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   typedef enum logic {
      LVL_LO = 1'b0,
      LVL_HI = 1'b1
   } irq_lvl_e;

   localparam int unsigned MAX_SRC = 32;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
   parameter int unsigned N_SRC    = 8,
   parameter logic [N_SRC-1:0] EDGE_SRC = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] irq_in,
   input  logic [N_SRC-1:0] clr_vec,
   output logic [N_SRC-1:0] pend
);
   logic [N_SRC-1:0] samp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) samp_q <= '0;
      else        samp_q <= irq_in;
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (EDGE_SRC[i]) begin : g_edge
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= (flag_q & ~clr_vec[i]) | (irq_in[i] & ~samp_q[i]);
         end
         assign pend[i] = flag_q;
      end else begin : g_level
         assign pend[i] = samp_q[i];
      end
   end
endmodule

// File: rtl/irq_select.sv
module irq_select #(
   parameter int unsigned N_SRC = 8,
   localparam int unsigned IW   = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0] elig,
   input  logic [N_SRC-1:0] lvl_hi,
   output logic             any,
   output logic [IW-1:0]    win_idx,
   output logic             win_hi
);
   logic [1:0]          lvl_any;
   logic [1:0][IW-1:0]  lvl_idx;

   for (genvar l = 0; l < 2; l++) begin : g_lvl
      logic [N_SRC-1:0] cand;
      assign cand = elig & (l == 1 ? lvl_hi : ~lvl_hi);
      always_comb begin
         lvl_any[l] = |cand;
         lvl_idx[l] = '0;
         for (int i = N_SRC - 1; i >= 0; i--) begin
            if (cand[i]) lvl_idx[l] = IW'(i);
         end
      end
   end

   assign any     = |lvl_any;
   assign win_hi  = lvl_any[1];
   assign win_idx = lvl_any[1] ? lvl_idx[1] : lvl_idx[0];
endmodule

// File: rtl/irq_nest.sv
module irq_nest (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_ev,
   input  logic ack_hi,
   input  logic reti_done,
   input  logic instr_retire,
   output logic isr_lo,
   output logic isr_hi,
   output logic gap
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_lo <= 1'b0;
         isr_hi <= 1'b0;
      end else if (ack_ev) begin
         if (ack_hi) isr_hi <= 1'b1;
         else        isr_lo <= 1'b1;
      end else if (reti_done) begin
         if (isr_hi) isr_hi <= 1'b0;
         else        isr_lo <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            gap <= 1'b0;
      else if (reti_done)    gap <= 1'b1;
      else if (instr_retire) gap <= 1'b0;
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int unsigned N_SRC    = 8,
   parameter logic [N_SRC-1:0] EDGE_SRC = '1,
   localparam int unsigned IW      = $clog2(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] irq_in,
   input  logic [N_SRC-1:0] irq_en,
   input  logic [N_SRC-1:0] irq_hi,
   input  logic             glb_en,
   input  logic             instr_retire,
   input  logic             reti_done,
   input  logic             call_ack,
   output logic             disp_req,
   output logic [IW-1:0]    disp_idx,
   output logic             disp_hi
);
   import prio_irq_pkg::*;

   if (N_SRC < 2 || N_SRC > MAX_SRC) begin : g_bad_n
      $error("prio_irq_ctrl: N_SRC out of range");
   end

   logic [N_SRC-1:0] pend, elig, clr_vec;
   logic             any, win_hi, can_go, ack_ev;
   logic [IW-1:0]    win_idx;
   logic             isr_lo, isr_hi, gap;
   logic             offer_q;
   logic [IW-1:0]    held_idx;
   irq_lvl_e         held_lvl;

   assign elig = pend & irq_en & {N_SRC{glb_en}};

   irq_capture #(.N_SRC(N_SRC), .EDGE_SRC(EDGE_SRC)) u_cap (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr_vec(clr_vec), .pend(pend)
   );

   irq_select #(.N_SRC(N_SRC)) u_sel (
      .elig(elig), .lvl_hi(irq_hi), .any(any), .win_idx(win_idx), .win_hi(win_hi)
   );

   irq_nest u_nest (
      .clk(clk), .rst_n(rst_n), .ack_ev(ack_ev), .ack_hi(disp_hi),
      .reti_done(reti_done), .instr_retire(instr_retire),
      .isr_lo(isr_lo), .isr_hi(isr_hi), .gap(gap)
   );

   assign can_go   = any & ~gap & ~isr_hi & (win_hi | ~isr_lo);
   assign disp_req = offer_q | can_go;
   assign disp_idx = offer_q ? held_idx : win_idx;
   assign disp_hi  = offer_q ? (held_lvl == LVL_HI) : win_hi;
   assign ack_ev   = call_ack & disp_req;

   always_comb begin
      clr_vec = '0;
      if (ack_ev) clr_vec[disp_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         offer_q  <= 1'b0;
         held_idx <= '0;
         held_lvl <= LVL_LO;
      end else if (call_ack) begin
         offer_q  <= 1'b0;
      end else if (can_go && !offer_q) begin
         offer_q  <= 1'b1;
         held_idx <= win_idx;
         held_lvl <= win_hi ? LVL_HI : LVL_LO;
      end
   end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
   parameter int unsigned N_SRC = 8,
   localparam int unsigned IW   = $clog2(N_SRC)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          call_ack,
   input logic          reti_done,
   input logic          disp_req,
   input logic [IW-1:0] disp_idx,
   input logic          disp_hi,
   input logic          isr_lo,
   input logic          isr_hi
);
   AST_OFFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      disp_req && !call_ack |=> disp_req && $stable(disp_idx) && $stable(disp_hi)); // R6
   AST_RET_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      reti_done && !disp_req |=> !disp_req); // R11
   AST_HI_NOT_PREEMPTED: assert property (@(posedge clk) disable iff (!rst_n)
      isr_hi |-> !disp_req); // R9
   AST_LO_ONLY_BY_HI: assert property (@(posedge clk) disable iff (!rst_n)
      isr_lo && disp_req |-> disp_hi); // R8
   AST_ACK_MARKS_HI: assert property (@(posedge clk) disable iff (!rst_n)
      call_ack && disp_req && disp_hi |=> isr_hi); // R7
   AST_ACK_MARKS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      call_ack && disp_req && !disp_hi |=> isr_lo); // R7
endmodule

bind prio_irq_ctrl prio_irq_chk #(.N_SRC(N_SRC)) u_chk (
   .clk(clk), .rst_n(rst_n), .call_ack(call_ack), .reti_done(reti_done),
   .disp_req(disp_req), .disp_idx(disp_idx), .disp_hi(disp_hi),
   .isr_lo(isr_lo), .isr_hi(isr_hi)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
   localparam int N = 8;
   localparam int IW = $clog2(N);

   logic clk = 1'b0, rst_n = 1'b0;
   logic [N-1:0] irq_in = '0, irq_en = '1, irq_hi = 8'hF0;
   logic glb_en = 1'b1, instr_retire = 1'b0, reti_done = 1'b0, call_ack = 1'b0;
   logic disp_req, disp_hi;
   logic [IW-1:0] disp_idx;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   logic [IW:0] exp_q[$];

   always #10 clk = ~clk;

   prio_irq_ctrl #(.N_SRC(N)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_en(irq_en), .irq_hi(irq_hi),
      .glb_en(glb_en), .instr_retire(instr_retire), .reti_done(reti_done),
      .call_ack(call_ack), .disp_req(disp_req), .disp_idx(disp_idx), .disp_hi(disp_hi)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // look: sample just after the falling edge, away from the active edge
   task automatic see_none(input string req);
      #2 chk(disp_req == 1'b0, req, disp_req, 0);
   endtask

   task automatic see(input string req, input int idx, input bit hi);
      #2 chk(disp_req && disp_idx == IW'(idx) && disp_hi == hi, req,
             {disp_req, disp_hi, 4'(disp_idx)}, {1'b1, hi, 4'(idx)});
   endtask

   task automatic raise(input logic [N-1:0] m);
      irq_in = m; tick(); irq_in = '0;
   endtask

   // driver: push expected dispatch, then accept it
   task automatic accept(input int idx, input bit hi);
      exp_q.push_back({hi, IW'(idx)});
      call_ack = 1'b1; tick(); call_ack = 1'b0;
   endtask

   task automatic ret_and_retire();
      reti_done = 1'b1; tick(); reti_done = 1'b0;
      instr_retire = 1'b1; tick(); instr_retire = 1'b0;
   endtask

   // monitor: compare every accepted dispatch with the scoreboard
   always @(negedge clk) begin
      #2;
      if (call_ack && rst_n) begin
         if (exp_q.size() == 0) chk(1'b0, "R7 unexpected accept", disp_idx, 0);
         else begin
            logic [IW:0] e;
            e = exp_q.pop_front();
            chk(disp_req && {disp_hi, disp_idx} == e, "R7 accepted vector",
                {disp_req, disp_hi, disp_idx}, {1'b1, e});
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      see_none("R1 in reset");
      rst_n = 1'b1;
      tick(); see_none("R1 after reset");

      // R3: one-clock detection, then four-clock call
      tick();
      irq_in = 8'h08; see_none("R3 before capture edge");
      tick(); irq_in = '0; see("R3 detect", 3, 0);
      tick(); see("R6 hold 1", 3, 0);
      tick(); see("R6 hold 2", 3, 0);
      tick(); accept(3, 0);
      see_none("R7 not reissued");

      // nesting: low in service
      raise(8'h02); see_none("R9 low held under low");
      raise(8'h20); see("R8 high preempts low", 5, 1);
      accept(5, 1);
      raise(8'h40); see_none("R9 high blocked by high");
      reti_done = 1'b1; tick(); reti_done = 1'b0;
      see_none("R11 gap after return");
      tick(); see_none("R11 gap persists without retire");
      instr_retire = 1'b1; tick(); instr_retire = 1'b0;
      see("R10 high cleared first", 6, 1);
      accept(6, 1);
      ret_and_retire(); see_none("R10 low still in service");
      reti_done = 1'b1; tick(); reti_done = 1'b0;
      see_none("R11 gap second return");
      instr_retire = 1'b1; tick(); instr_retire = 1'b0;
      see("R10 low cleared", 1, 0);
      accept(1, 0);
      ret_and_retire(); see_none("R7 queue empty");

      // R4/R5: simultaneous requests
      raise(8'h94); see("R4 high wins", 4, 1);
      accept(4, 1); see_none("R9 second high waits");
      ret_and_retire(); see("R5 next high", 7, 1);
      accept(7, 1);
      ret_and_retire(); see("R4 low after highs", 2, 0);
      accept(2, 0);
      ret_and_retire(); see_none("R1 idle");
      raise(8'h09); see("R5 lowest index", 0, 0);
      accept(0, 0);
      ret_and_retire(); see("R5 next low", 3, 0);
      accept(3, 0);
      ret_and_retire(); see_none("R5 done");

      // R2: masking
      irq_en = ~8'h04;
      raise(8'h04); see_none("R2 source disabled");
      glb_en = 1'b0; irq_en = '1;
      tick(); see_none("R2 global disabled");
      glb_en = 1'b1;
      tick(); see("R2 latched edge offered", 2, 0);
      accept(2, 0);
      ret_and_retire(); see_none("R2 done");

      // R6: offer held while a more urgent request arrives
      raise(8'h02); see("R6 low offered", 1, 0);
      raise(8'h40); see("R6 offer unchanged", 1, 0);
      accept(1, 0);
      see("R8 pending high after low accept", 6, 1);
      accept(6, 1);
      ret_and_retire(); see_none("R9 low level still busy");
      ret_and_retire(); see_none("R1 final idle");

      tick(); tick();
      chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule